// File: doc/BRIEF.md
# Field Extract/Insert Unit

A combinational shift-mask-merge unit for a 32-bit datapath. It joins a left and a right operand into one 64-bit value with the left operand on top. It shifts that value left by a programmable count and takes the upper word as the funnel output. It then keeps only a right-aligned field of programmable width. In insert mode, the field is merged back into the right operand, so the right operand's bits outside the inserted window are kept.

The control word for the operation can come from either of two places: a dedicated field register input or the immediate constant bus. A select input picks the source. Both sources are decoded the same way, and only the low 16 bits of the chosen word carry meaning. If the shift count or the width is out of range, the value is clamped to 32 and an error output is raised. The unit has no registers, so the result settles in the same cycle as its inputs.

Top module: `field_unit`

## Requirements
- R1: The chosen control word is decoded as follows: shift count in bits [5:0], field width in bits [11:6], insert flag in bit 12. Bits [31:13] have no effect on any output.
- R2: When the shift count is 0, the funnel output equals the left operand. With width 32 and insert clear, `result` then equals `lhs`.
- R3: When the shift count is 32, the funnel output equals the right operand. With width 32, `result` then equals `rhs` in both modes.
- R4: For a shift count s from 1 to 31, bit i of the funnel output is `lhs[i-s]` for i >= s and `rhs[32-s+i]` for i < s.
- R5: With insert clear, `result` is the funnel output ANDed with a mask that has its low m bits set, where m is the width. Width 0 gives a zero result.
- R6: With insert set, `rhs` bit i is also ORed into `result` wherever (i < m) equals (i < s).
- R7: When `use_const` is 1, the control word is taken from `kconst`. When it is 0, the control word is taken from `fld_reg`. The word that is not selected has no effect.
- R8: A shift count or width above 32 sets `desc_err` to 1, and that value acts as 32. When both values are 32 or less, `desc_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lhs | input | 32 | Left operand, upper half of the funnel |
| rhs | input | 32 | Right operand, lower half of the funnel and insert target |
| fld_reg | input | 32 | Control word from the field register |
| kconst | input | 32 | Control word from the constant bus |
| use_const | input | 1 | 1 selects `kconst`, 0 selects `fld_reg` |
| result | output | 32 | Extracted or merged field |
| desc_err | output | 1 | Shift count or width out of range |

## Verification
The unit is swept across every pair of shift count and width from 0 to 32, in both extract and insert mode. Random operands are used, and the source select alternates. The sweep separates the two funnel halves at each boundary, including the pass-through cases at 0 and 32. It also separates the width mask from the shift-derived insert window. Junk is placed in the ignored control bits and in the unselected source, so an error in the field decode or in the source mux shows up. Over-range counts in each field, alone and together, check both the clamp and the error flag.

// File: rtl/field_unit.sv
module field_unit #(
  parameter int W = 32
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic [W-1:0] fld_reg,
  input  logic [W-1:0] kconst,
  input  logic         use_const,
  output logic [W-1:0] result,
  output logic         desc_err
);
  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [W-1:0]   ctl;
  logic [CW-1:0]  raw_s, raw_m, s_eff, m_eff;
  logic           ins;
  logic [2*W-1:0] funnel;
  logic [W-1:0]   shifted, mask_m, mask_s, keep;

  assign ctl   = use_const ? kconst : fld_reg;
  assign raw_s = ctl[CW-1:0];
  assign raw_m = ctl[2*CW-1:CW];
  assign ins   = ctl[2*CW];

  assign s_eff    = (raw_s > FULL) ? FULL : raw_s;
  assign m_eff    = (raw_m > FULL) ? FULL : raw_m;
  assign desc_err = (raw_s > FULL) || (raw_m > FULL);

  assign funnel  = {lhs, rhs} << s_eff;
  assign shifted = funnel[2*W-1:W];

  assign mask_m = ~({W{1'b1}} << m_eff);
  assign mask_s = ~({W{1'b1}} << s_eff);
  assign keep   = ins ? (rhs & ~(mask_m ^ mask_s)) : '0;

  assign result = (shifted & mask_m) | keep;

  always_comb begin
    if (s_eff == '0 && m_eff == FULL && !ins)
      AST_PASS_LEFT: assert (result == lhs) else $error("left pass"); // R2
    if (s_eff == FULL && m_eff == FULL)
      AST_PASS_RIGHT: assert (result == rhs) else $error("right pass"); // R3
    if (m_eff == '0 && !ins)
      AST_ZERO_WIDTH: assert (result == '0) else $error("zero width"); // R5
    if (!ins && m_eff < FULL)
      AST_HIGH_CLEAR: assert ((result >> m_eff) == '0) else $error("high bits"); // R5
    if (desc_err)
      AST_ERR_CLAMP: assert (s_eff == FULL || m_eff == FULL) else $error("clamp"); // R8
  end
endmodule

// File: tb/field_unit_bench.sv
module field_unit_bench;
  logic        clk = 1'b0;
  logic [31:0] lhs, rhs, fld_reg, kconst;
  logic        use_const;
  logic [31:0] result;
  logic        desc_err;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  field_unit u_field_unit (
    .lhs(lhs), .rhs(rhs), .fld_reg(fld_reg), .kconst(kconst),
    .use_const(use_const), .result(result), .desc_err(desc_err)
  );

  function automatic logic [31:0] mk(int s, int m, bit ins, logic [18:0] junk);
    logic [31:0] w;
    w = {junk, ins, 6'(m), 6'(s)};
    return w;
  endfunction

  function automatic logic [32:0] model(logic [31:0] a, logic [31:0] b, logic [31:0] d);
    int s, m;
    bit ins, err;
    logic [31:0] r;
    s = int'(d[5:0]);
    m = int'(d[11:6]);
    ins = d[12];
    err = (s > 32) || (m > 32);
    if (s > 32) s = 32;
    if (m > 32) m = 32;
    for (int i = 0; i < 32; i++) begin
      bit f;
      f = (i >= s) ? a[i-s] : b[32-s+i];
      r[i] = (i < m) ? f : 1'b0;
      if (ins && ((i < m) == (i < s))) r[i] = r[i] | b[i];
    end
    return {err, r};
  endfunction

  task automatic apply(logic [31:0] a, logic [31:0] b, logic [31:0] d, bit sel, string tag);
    logic [32:0] exp;
    @(posedge clk);
    #1;
    lhs = a; rhs = b; use_const = sel;
    if (sel) begin kconst = d; fld_reg = $urandom(); end
    else     begin fld_reg = d; kconst = $urandom(); end
    exp = model(a, b, d);
    @(negedge clk);
    total++;
    if ({desc_err, result} !== exp) begin
      bad++;
      $display("FAIL %s: got err=%0b res=%08h expected err=%0b res=%08h",
               tag, desc_err, result, exp[32], exp[31:0]);
    end
  endtask

  initial begin
    lhs = '0; rhs = '0; fld_reg = '0; kconst = '0; use_const = 1'b0;
    apply(32'hDEADBEEF, 32'h12345678, 32'h0, 1'b0, "R5 zero descriptor");
    apply(32'hA5A5F00F, 32'h0F0F1234, mk(0, 32, 0, 19'h0), 1'b0, "R2 shift 0");
    apply(32'hA5A5F00F, 32'h0F0F1234, mk(32, 32, 0, 19'h0), 1'b1, "R3 shift 32");
    apply(32'hA5A5F00F, 32'h0F0F1234, mk(32, 32, 1, 19'h0), 1'b0, "R3 shift 32 insert");
    apply(32'h80000001, 32'hC0000000, mk(1, 32, 0, 19'h0), 1'b1, "R4 shift 1");
    apply(32'h00000001, 32'hFFFFFFFE, mk(31, 32, 0, 19'h0), 1'b0, "R4 shift 31");
    apply(32'hFFFFFFFF, 32'h00000000, mk(8, 12, 1, 19'h7FFFF), 1'b1, "R1 R6 junk bits");
    for (int ins = 0; ins < 2; ins++)
      for (int s = 0; s <= 32; s++)
        for (int m = 0; m <= 32; m++)
          apply($urandom(), $urandom(), mk(s, m, ins[0], 19'($urandom())),
                ((s + m) % 2) == 1, "R4 R5 R6 R7 sweep");
    for (int v = 33; v < 64; v++) begin
      apply($urandom(), $urandom(), mk(v, $urandom_range(32), v[0], 19'h0), 1'b0, "R8 shift over range");
      apply($urandom(), $urandom(), mk($urandom_range(32), v, v[1], 19'h0), 1'b1, "R8 width over range");
      apply($urandom(), $urandom(), mk(v, v, 1'b1, 19'h0), v[0], "R8 both over range");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule